// File: doc/BRIEF.md
# Packet CRC Checker and Stripper

This block sits between a frame buffer and the logical-layer handlers of a serial-link endpoint. The packets arrive as a stream of 32-bit words. The first word carries a start marker, the final word carries an end marker, and a pad marker shows whether the final word holds only one meaningful halfword. The block runs a 16-bit CCITT CRC over the packet and checks every CRC field it finds. It then forwards the packet as a re-packed word stream with all CRC halfwords and padding removed.

There are two kinds of CRC field. Long packets carry an embedded CRC halfword after their first 80 bytes, and every packet ends in a trailing CRC halfword. Removing the embedded field moves everything after it by one halfword. Each output word after that point therefore joins halfwords taken from two input words. The running CRC continues through the embedded field, so the trailing field covers the embedded one as well.

Both sides use valid/ready handshakes. When the downstream side stops accepting words, the block stops taking input. The last output word of a packet carries a last flag, a pad flag and the packet's error flag.

Top module: `crcStrip`

## Requirements
- R1: The CRC is the non-reflected 16-bit polynomial 0x1021, fed most significant bit first and preset to 0xFFFF for every packet. Each 32-bit word enters as its upper halfword (bits 31:16) followed by its lower halfword (bits 15:0). A correctly formed packet, including one sent straight after another packet, ends with the error flag low.
- R2: Data halfwords leave in their input order. They are packed two per output word, the earlier halfword in bits 31:16. The trailing CRC halfword is never forwarded.
- R3: Halfword position 40 (bytes 80 and 81, counted from 0) is the embedded CRC field whenever it is not the trailing CRC. That field is removed, and later data is realigned by 16 bits so that no gap appears in the output.
- R4: A packet with exactly 80 data bytes has no embedded field. Its halfword 40 is the trailing CRC, and all 40 data halfwords are forwarded.
- R5: When the pad marker is high on the end word, bits 31:16 of that word are the trailing CRC and bits 15:0 are padding. Both are discarded. When the pad marker is low, bits 15:0 of the end word are the trailing CRC.
- R6: The last output word of a packet has the last flag high. If the packet has an odd number of data halfwords, that word also has the pad flag high and bits 15:0 equal to zero. The pad flag is never high without the last flag.
- R7: The trailing field is compared with the CRC of every halfword before it, including the embedded field. A mismatch raises the error flag on the last output word. The error flag is low on every other output word.
- R8: The embedded field is compared with the CRC of the halfwords before it. A mismatch raises the packet's error flag even when the trailing field is consistent.
- R9: The error flag is cleared between packets. A clean packet that follows a failing packet reports no error.
- R10: While an output word is offered but not accepted, the word and its flags stay unchanged. Under any pattern of input gaps and output stalls, no data halfword is lost or repeated. Once the end word is accepted, no new input is taken until the last output word has been accepted.
- R11: After reset is asserted (active low, asynchronous), no output word is offered and input is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input word is offered |
| inReady | output | 1 | Block takes the input word on this edge |
| inData | input | 32 | Input word |
| inFirst | input | 1 | Word is the first of a packet |
| inLast | input | 1 | Word is the last of a packet |
| inPad | input | 1 | End word holds the trailing CRC in bits 31:16 and padding below |
| outValid | output | 1 | Output word is offered |
| outReady | input | 1 | Downstream takes the output word |
| outData | output | 32 | Re-packed data word |
| outLast | output | 1 | Word is the last of the packet |
| outPad | output | 1 | Only bits 31:16 of the last word hold data |
| outErr | output | 1 | A CRC field of the packet mismatched (with last only) |

## Verification
The bench builds the block with its default parameters: the embedded field at byte 80, a 0xFFFF preset and the 0x1021 polynomial. Because the position is the full-size one, the tests use packets of 40, 41 and about 50 data halfwords. These sizes cover the exact-80-byte boundary, a single data halfword after the embedded field, and long runs of realigned words. With the default position limit of 80 words, these packets stay well clear of counter saturation. The same parameters also make it possible to corrupt only the embedded field, only the trailing field, or neither, while input gaps and output stalls are applied.

// File: rtl/crcStripPkg.sv
package crcStripPkg;

  localparam int HW_W     = 16;
  localparam int HW_SLOTS = 4;

  typedef struct packed {
    logic push;    // input word taken this cycle
    logic keepHi;  // bits 31:16 are data
    logic keepLo;  // bits 15:0 are data
    logic last;    // word ends the packet
  } stripCtl_t;

  function automatic logic [HW_W-1:0] crcStep(input logic [HW_W-1:0] c,
                                              input logic [HW_W-1:0] d,
                                              input logic [HW_W-1:0] poly);
    logic [HW_W-1:0] r;
    r = c;
    for (int i = HW_W - 1; i >= 0; i--) begin
      if (r[HW_W-1] ^ d[i]) r = {r[HW_W-2:0], 1'b0} ^ poly;
      else                  r = {r[HW_W-2:0], 1'b0};
    end
    return r;
  endfunction

endpackage

// File: rtl/crcStripCtl.sv
module crcStripCtl
  import crcStripPkg::*;
#(
  parameter int          EMB_BYTES = 80,
  parameter int          MAX_WORDS = 80,
  parameter logic [15:0] CRC_INIT  = 16'hFFFF,
  parameter logic [15:0] CRC_POLY  = 16'h1021
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inFirst,
  input  logic        inLast,
  input  logic        inPad,
  input  logic [31:0] inData,
  input  logic        inReady,
  input  logic        pktDone,
  output stripCtl_t   ctl,
  output logic        errFlag
);

  localparam int EMB_WORD = EMB_BYTES / 4;
  localparam int POS_W    = $clog2(MAX_WORDS + 1);

  logic [POS_W-1:0] pos, wordIdx, posNxt;
  logic [15:0]      crcReg, crcBase, crcMid, crcEnd, hiHw, loHw;
  logic             fire, embHit, padEnd, mism, errBase;

  always_comb begin
    hiHw    = inData[31:16];
    loHw    = inData[15:0];
    fire    = inValid && inReady;
    wordIdx = inFirst ? '0 : pos;
    padEnd  = inLast && inPad;
    embHit  = (wordIdx == POS_W'(EMB_WORD)) && !padEnd;
    crcBase = inFirst ? CRC_INIT : crcReg;
    crcMid  = crcStep(crcBase, hiHw, CRC_POLY);
    crcEnd  = crcStep(crcMid, loHw, CRC_POLY);
    // each field is compared with the CRC taken just before it
    mism    = (embHit && (crcBase != hiHw)) ||
              (inLast && (padEnd ? (crcBase != hiHw) : (crcMid != loHw)));
    errBase = inFirst ? 1'b0 : errFlag;
    if (inLast)                              posNxt = '0;
    else if (wordIdx == POS_W'(MAX_WORDS))   posNxt = wordIdx;
    else                                     posNxt = wordIdx + POS_W'(1);
    ctl.push   = fire;
    ctl.keepHi = !embHit && !padEnd;
    ctl.keepLo = !inLast;
    ctl.last   = inLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pos     <= '0;
      crcReg  <= CRC_INIT;
      errFlag <= 1'b0;
    end else if (fire) begin
      pos     <= posNxt;
      crcReg  <= inLast ? CRC_INIT : crcEnd;
      errFlag <= errBase || mism;
    end else if (pktDone) begin
      errFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/crcStripDp.sv
module crcStripDp
  import crcStripPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  stripCtl_t   ctl,
  input  logic [31:0] inData,
  input  logic        outReady,
  output logic        inReady,
  output logic        outValid,
  output logic [31:0] outData,
  output logic        outLast,
  output logic        outPad,
  output logic        pktDone
);

  localparam int CNT_W = $clog2(HW_SLOTS + 1);

  logic [HW_W-1:0]  slot    [HW_SLOTS];
  logic [HW_W-1:0]  slotNxt [HW_SLOTS];
  logic [CNT_W-1:0] cnt, cntPop, cntNxt, idxHi, idxLo;
  logic             ending, pop, putHi, putLo;

  always_comb begin
    outValid = (cnt >= CNT_W'(3)) || ending;
    outLast  = ending && (cnt <= CNT_W'(2));
    outPad   = outLast && (cnt <= CNT_W'(1));
    outData  = {(cnt != '0) ? slot[0] : '0, (cnt >= CNT_W'(2)) ? slot[1] : '0};
    pop      = outValid && outReady;
    pktDone  = pop && outLast;
    inReady  = !ending && ((cnt <= CNT_W'(2)) || outReady);

    putHi  = ctl.push && ctl.keepHi;
    putLo  = ctl.push && ctl.keepLo;
    if (pktDone)  cntPop = '0;
    else if (pop) cntPop = cnt - CNT_W'(2);
    else          cntPop = cnt;
    idxHi  = cntPop;
    idxLo  = cntPop + CNT_W'(putHi);
    cntNxt = cntPop + CNT_W'(putHi) + CNT_W'(putLo);

    for (int i = 0; i < HW_SLOTS; i++) slotNxt[i] = slot[i];
    for (int i = 0; i < HW_SLOTS - 2; i++) if (pop) slotNxt[i] = slot[i+2];
    for (int i = 0; i < HW_SLOTS; i++) begin
      if (putHi && (idxHi == CNT_W'(i))) slotNxt[i] = inData[31:16];
      if (putLo && (idxLo == CNT_W'(i))) slotNxt[i] = inData[15:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      ending <= 1'b0;
      for (int i = 0; i < HW_SLOTS; i++) slot[i] <= '0;
    end else begin
      cnt <= cntNxt;
      for (int i = 0; i < HW_SLOTS; i++) slot[i] <= slotNxt[i];
      if (pktDone)                   ending <= 1'b0;
      else if (ctl.push && ctl.last) ending <= 1'b1;
    end
  end

endmodule

// File: rtl/crcStrip.sv
module crcStrip
  import crcStripPkg::*;
#(
  parameter int          EMB_BYTES = 80,
  parameter int          MAX_WORDS = 80,
  parameter logic [15:0] CRC_INIT  = 16'hFFFF,
  parameter logic [15:0] CRC_POLY  = 16'h1021
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  input  logic [31:0] inData,
  input  logic        inFirst,
  input  logic        inLast,
  input  logic        inPad,
  output logic        outValid,
  input  logic        outReady,
  output logic [31:0] outData,
  output logic        outLast,
  output logic        outPad,
  output logic        outErr
);

  stripCtl_t ctl;
  logic      pktDone, errFlag;

  crcStripCtl #(
    .EMB_BYTES(EMB_BYTES), .MAX_WORDS(MAX_WORDS),
    .CRC_INIT(CRC_INIT), .CRC_POLY(CRC_POLY)
  ) i_ctl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inFirst(inFirst),
    .inLast(inLast), .inPad(inPad), .inData(inData), .inReady(inReady),
    .pktDone(pktDone), .ctl(ctl), .errFlag(errFlag)
  );

  crcStripDp i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inData(inData), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .outData(outData),
    .outLast(outLast), .outPad(outPad), .pktDone(pktDone)
  );

  assign outErr = outLast && errFlag;

endmodule

// File: rtl/crcStripChk.sv
module crcStripChk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        inReady,
  input logic        inLast,
  input logic        outValid,
  input logic        outReady,
  input logic [31:0] outData,
  input logic        outLast,
  input logic        outPad,
  input logic        outErr
);

  // R10: an offered word holds until taken
  a_r10_hold_word: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outLast)
                              && $stable(outPad) && $stable(outErr));

  // R10: after the end word is taken, input closes
  a_r10_close_input: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady && inLast |=> !inReady);

  // R7: error flag only on the last offered word
  a_r7_err_on_last: assert property (@(posedge clk) disable iff (!rstN)
    outErr |-> outLast && outValid);

  // R6: pad implies last and a zero lower half
  a_r6_pad_zero: assert property (@(posedge clk) disable iff (!rstN)
    outPad |-> outLast && (outData[15:0] == 16'h0));

endmodule

bind crcStrip crcStripChk i_crcStripChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .inLast(inLast), .outValid(outValid), .outReady(outReady),
  .outData(outData), .outLast(outLast), .outPad(outPad), .outErr(outErr)
);

// File: tb/test_crcStrip.sv
module test_crcStrip;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0, inFirst = 1'b0, inLast = 1'b0, inPad = 1'b0;
  logic [31:0] inData = '0;
  logic        outReady = 1'b1;
  logic        inReady, outValid, outLast, outPad, outErr;
  logic [31:0] outData;

  int nChecks = 0;
  int nErrors = 0;
  int rdyMode = 0;
  int cyc = 0;

  logic [15:0] dHw [0:127];
  logic [15:0] sHw [0:159];
  logic [31:0] gotD [0:255];
  bit          gotLast [0:255];
  bit          gotPad  [0:255];
  bit          gotErr  [0:255];
  int          gotN = 0;

  crcStrip i_crcStrip (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inFirst(inFirst), .inLast(inLast), .inPad(inPad),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .outLast(outLast), .outPad(outPad), .outErr(outErr)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [15:0] benchCrc(input logic [15:0] c, input logic [15:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 15; i >= 0; i--) begin
      if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ 16'h1021;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // output ready pattern
  always @(negedge clk) begin
    cyc <= cyc + 1;
    case (rdyMode)
      1:       outReady <= cyc[0];
      2:       outReady <= ((cyc % 3) == 0);
      default: outReady <= 1'b1;
    endcase
  end

  // output monitor, sampled away from the edge
  always @(negedge clk) begin
    #2;
    if (rstN && outValid && outReady && gotN < 256) begin
      gotD[gotN]    = outData;
      gotLast[gotN] = outLast;
      gotPad[gotN]  = outPad;
      gotErr[gotN]  = outErr;
      gotN++;
    end
  end

  task automatic runPacket(input int n, input int seed, input bit badEmb,
                           input bit badTrl, input bit gaps,
                           input string dataReq, input string errReq);
    logic [15:0] crc, e;
    int m, nw, expN, badIdx;
    bit padded;
    logic [31:0] expW;
    crc = 16'hFFFF;
    m = 0;
    for (int i = 0; i < n; i++) dHw[i] = 16'((seed * 977 + i * 4099 + i * i * 13) & 32'hFFFF);
    for (int i = 0; i < n; i++) begin
      if (i == 40 && n > 40) begin
        e = crc ^ (badEmb ? 16'h0001 : 16'h0000);
        sHw[m] = e; m++;
        crc = benchCrc(crc, e);
      end
      sHw[m] = dHw[i]; m++;
      crc = benchCrc(crc, dHw[i]);
    end
    sHw[m] = crc ^ (badTrl ? 16'h8000 : 16'h0000); m++;
    padded = (m % 2) == 1;
    if (padded) begin sHw[m] = 16'h0; m++; end
    nw = m / 2;
    expN = (n + 1) / 2;
    gotN = 0;

    for (int w = 0; w < nw; w++) begin
      if (gaps && (w % 3 == 1)) begin
        @(negedge clk);
        inValid = 1'b0;
      end
      @(negedge clk);
      inValid = 1'b1;
      inData  = {sHw[2*w], sHw[2*w+1]};
      inFirst = (w == 0);
      inLast  = (w == nw - 1);
      inPad   = (w == nw - 1) && padded;
      #1;
      while (!inReady) begin
        @(negedge clk);
        #1;
      end
    end
    @(negedge clk);
    inValid = 1'b0; inFirst = 1'b0; inLast = 1'b0; inPad = 1'b0;

    for (int g = 0; g < 3000; g++) begin
      if (gotN > 0 && gotLast[gotN-1]) break;
      @(negedge clk);
      #3;
    end

    chk(gotN == expN, dataReq, "word count", gotN, expN);
    badIdx = -1;
    for (int j = 0; j < expN && j < gotN; j++) begin
      expW = {dHw[2*j], (2*j+1 < n) ? dHw[2*j+1] : 16'h0};
      if (gotD[j] !== expW && badIdx < 0) badIdx = j;
    end
    if (badIdx >= 0)
      chk(1'b0, dataReq, "data word", gotD[badIdx],
          {dHw[2*badIdx], (2*badIdx+1 < n) ? dHw[2*badIdx+1] : 16'h0});
    else
      chk(1'b1, dataReq, "data word", 0, 0);
    if (gotN > 0) begin
      chk(gotLast[gotN-1] == 1'b1, "R6", "last flag", gotLast[gotN-1], 1);
      chk(gotPad[gotN-1] == (n % 2 == 1), "R6", "pad flag", gotPad[gotN-1], n % 2);
      chk(gotErr[gotN-1] == (badEmb || badTrl), errReq, "error flag",
          gotErr[gotN-1], badEmb || badTrl);
      for (int j = 0; j < gotN - 1; j++) begin
        if (gotLast[j] || gotErr[j] || gotPad[j]) begin
          chk(1'b0, "R7", "flag on inner word", j, -1);
          break;
        end
      end
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    #1;
    chk(outValid == 1'b0, "R11", "outValid after reset", outValid, 0);
    chk(inReady == 1'b1, "R11", "inReady after reset", inReady, 1);
  endtask

  task automatic t_short;
    runPacket(5, 1, 0, 0, 0, "R2", "R1");   // crc in lower half
    runPacket(6, 2, 0, 0, 0, "R5", "R1");   // crc upper, pad below
  endtask

  task automatic t_exact80;
    runPacket(40, 3, 0, 0, 0, "R4", "R1");
  endtask

  task automatic t_long;
    runPacket(41, 4, 0, 0, 0, "R3", "R1");
    runPacket(46, 5, 0, 0, 0, "R3", "R1");
    runPacket(49, 6, 0, 0, 0, "R3", "R1");
  endtask

  task automatic t_badCrc;
    runPacket(12, 7, 0, 1, 0, "R2", "R7");
    runPacket(50, 8, 1, 0, 0, "R3", "R8");
    runPacket(47, 9, 0, 1, 0, "R3", "R7");
    runPacket(9, 10, 0, 0, 0, "R2", "R9");
  endtask

  task automatic t_stall;
    rdyMode = 2;
    runPacket(47, 11, 0, 0, 1, "R10", "R1");
    rdyMode = 1;
    runPacket(44, 12, 0, 0, 1, "R10", "R1");
    runPacket(7, 13, 0, 1, 1, "R10", "R7");
    rdyMode = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_short();
    t_exact80();
    t_long();
    t_badCrc();
    t_stall();
    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

endmodule